// File: doc/BRIEF.md
# Dual-Bank ECC Slice Memory

This block is the local row store that sits beside one wide SIMD compute slice. It holds two independent banks. The operand bank holds activations and other data. The weight bank holds coefficients. Each bank is an array of full-width rows, and every access moves a whole row. In any one cycle a single write may go to the bank chosen by a select input, and both banks may be read through their own read ports.

Each row is split into 64-bit words. Each word is stored with an 8-bit single-error-correct, double-error-detect code: seven Hamming check bits plus one overall parity bit. On a read, every word is decoded separately. A single flipped bit is repaired in the returned data and raises a correctable flag for that word. Two flipped bits raise an uncorrectable flag for that word. The write port also takes a flip mask, which is XORed into the encoded row as it is stored. This lets a test corrupt chosen stored bits and exercise both the repair path and the detection path.

Top module: `dual_bank_ecc_mem`

## Requirements
- R1: While reset is held and after it is released, both read ports show valid low, row data zero and all error flags zero until the first read.
- R2: A write with `wr_bank`=0 stores the row in the operand bank and a write with `wr_bank`=1 stores it in the weight bank. A later read of that row returns it on that bank's port and leaves the other bank's contents unchanged.
- R3: Both read ports can be served in the same cycle as a write, and each returns the contents of its own bank.
- R4: A read request in cycle N gives valid high and the row data in cycle N+1. A cycle without a request gives valid low in the following cycle.
- R5: A read of the row being written in the same bank in the same cycle returns the row's old contents. The new contents appear on the next read.
- R6: If exactly one bit is set in the 72-bit flip-mask slice [72k+71:72k] of word k, the read returns the written data for word k (row bits [64k+63:64k]). Correctable flag bit k is set and uncorrectable flag bit k is clear.
- R7: If exactly two bits are set in the flip-mask slice of word k, uncorrectable flag bit k is set and correctable flag bit k is clear.
- R8: Errors are reported per word. Flag bits of words with no flipped bits stay clear, and words with different error kinds in the same row are each flagged on their own.
- R9: Error flags are zero whenever valid is low. Row data holds its last read value until the next read on that port.
- R10: For no word are the correctable and uncorrectable flags set together.
- R11: The last row index (row count minus one) can be written and read back in both banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_bank | input | 1 | Target bank: 0 operand, 1 weight |
| wr_row | input | ROW_AW | Row index for the write |
| wr_data | input | ROW_BITS | Full row of write data |
| wr_flip | input | WORDS*72 | Test mask XORed into the stored encoded row |
| od_rd_en | input | 1 | Operand bank read request |
| od_rd_row | input | ROW_AW | Operand bank read row |
| od_rd_valid | output | 1 | Operand read data valid |
| od_rd_data | output | ROW_BITS | Operand corrected row data |
| od_rd_cerr | output | WORDS | Operand per-word corrected-error flags |
| od_rd_uerr | output | WORDS | Operand per-word uncorrectable-error flags |
| wt_rd_en | input | 1 | Weight bank read request |
| wt_rd_row | input | ROW_AW | Weight bank read row |
| wt_rd_valid | output | 1 | Weight read data valid |
| wt_rd_data | output | ROW_BITS | Weight corrected row data |
| wt_rd_cerr | output | WORDS | Weight per-word corrected-error flags |
| wt_rd_uerr | output | WORDS | Weight per-word uncorrectable-error flags |

## Verification
The checker watches every cycle on both ports. It checks that valid follows a read request by exactly one cycle, that flags stay quiet without valid, that held data does not move between reads, and that no word reports both error kinds at once. Only the directed scenarios can show that the correct bank was written, that a same-row read sees the old contents, and that single flips are repaired while double flips are flagged in the right word. These depend on the data that was stored, which a per-cycle property does not track.

// File: rtl/slice_mem_pkg.sv
package slice_mem_pkg;

    localparam int WORD_W  = 64;
    localparam int CHK_W   = 8;
    localparam int CW_W    = WORD_W + CHK_W;   // 72
    localparam int SYN_W   = 7;
    localparam int HAM_TOP = CW_W - 1;         // highest Hamming position (71)

    typedef enum logic {
        BANK_OPERAND = 1'b0,
        BANK_WEIGHT  = 1'b1
    } bank_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              cerr;
        logic              uerr;
    } dec_word_t;

    function automatic logic is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // Codeword layout: bit 0 overall parity, bits 1..71 Hamming positions,
    // check bits at power-of-two positions, data bits in the remainder.
    function automatic logic [CW_W-1:0] ecc_encode(input logic [WORD_W-1:0] d);
        logic [CW_W-1:0] cw;
        int unsigned     di;
        cw = '0;
        di = 0;
        for (int unsigned p = 1; p <= HAM_TOP; p++) begin
            if (!is_pow2(p)) begin
                cw[p] = d[di];
                di++;
            end
        end
        for (int unsigned j = 0; j < SYN_W; j++) begin
            logic acc;
            acc = 1'b0;
            for (int unsigned p = 1; p <= HAM_TOP; p++) begin
                if (((p >> j) & 1) != 0 && !is_pow2(p)) acc ^= cw[p];
            end
            cw[1 << j] = acc;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic dec_word_t ecc_decode(input logic [CW_W-1:0] cw_in);
        dec_word_t       r;
        logic [CW_W-1:0] cw;
        logic [SYN_W-1:0] syn;
        logic            ovp;
        int unsigned     di;
        cw  = cw_in;
        syn = '0;
        for (int unsigned p = 1; p <= HAM_TOP; p++) begin
            if (cw[p]) syn ^= SYN_W'(p);
        end
        ovp    = ^cw;
        r.cerr = 1'b0;
        r.uerr = 1'b0;
        if (ovp) begin
            if (syn == '0) begin
                r.cerr = 1'b1;               // parity bit itself flipped
            end else if (int'(syn) <= HAM_TOP) begin
                cw[syn] = ~cw[syn];
                r.cerr  = 1'b1;
            end else begin
                r.uerr = 1'b1;               // syndrome outside codeword
            end
        end else if (syn != '0) begin
            r.uerr = 1'b1;
        end
        di     = 0;
        r.data = '0;
        for (int unsigned p = 1; p <= HAM_TOP; p++) begin
            if (!is_pow2(p)) begin
                r.data[di] = cw[p];
                di++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/slice_row_encode.sv
module slice_row_encode
    import slice_mem_pkg::*;
#(
    parameter int WORDS = 32
) (
    input  logic [WORDS*WORD_W-1:0] row_data,
    output logic [WORDS*CW_W-1:0]   row_cw
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_comb row_cw[w*CW_W +: CW_W] = ecc_encode(row_data[w*WORD_W +: WORD_W]);
    end
endmodule

// File: rtl/slice_row_decode.sv
module slice_row_decode
    import slice_mem_pkg::*;
#(
    parameter int WORDS = 32
) (
    input  logic [WORDS*CW_W-1:0]   row_cw,
    output logic [WORDS*WORD_W-1:0] row_data,
    output logic [WORDS-1:0]        word_cerr,
    output logic [WORDS-1:0]        word_uerr
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        dec_word_t dw;
        always_comb begin
            dw = ecc_decode(row_cw[w*CW_W +: CW_W]);
            row_data[w*WORD_W +: WORD_W] = dw.data;
            word_cerr[w] = dw.cerr;
            word_uerr[w] = dw.uerr;
        end
    end
endmodule

// File: rtl/slice_mem_bank.sv
module slice_mem_bank #(
    parameter int ROWS  = 2048,
    parameter int CW_T  = 2304,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [CW_T-1:0] wdata,
    input  logic            re,
    input  logic [AW-1:0]   raddr,
    output logic [CW_T-1:0] rdata_q,
    output logic            rvalid_q
);
    logic [CW_T-1:0] store [ROWS];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Nonblocking read of the array gives the pre-write contents.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= re;
            if (re) rdata_q <= store[raddr];
        end
    end
endmodule

// File: rtl/dual_bank_ecc_mem.sv
module dual_bank_ecc_mem
    import slice_mem_pkg::*;
#(
    parameter int ROWS      = 2048,
    parameter int ROW_BYTES = 256,
    localparam int ROW_BITS = ROW_BYTES * 8,
    localparam int WORDS    = ROW_BITS / WORD_W,
    localparam int CW_T     = WORDS * CW_W,
    localparam int ROW_AW   = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_bank,
    input  logic [ROW_AW-1:0]   wr_row,
    input  logic [ROW_BITS-1:0] wr_data,
    input  logic [CW_T-1:0]     wr_flip,
    input  logic                od_rd_en,
    input  logic [ROW_AW-1:0]   od_rd_row,
    output logic                od_rd_valid,
    output logic [ROW_BITS-1:0] od_rd_data,
    output logic [WORDS-1:0]    od_rd_cerr,
    output logic [WORDS-1:0]    od_rd_uerr,
    input  logic                wt_rd_en,
    input  logic [ROW_AW-1:0]   wt_rd_row,
    output logic                wt_rd_valid,
    output logic [ROW_BITS-1:0] wt_rd_data,
    output logic [WORDS-1:0]    wt_rd_cerr,
    output logic [WORDS-1:0]    wt_rd_uerr
);
    localparam int NBANK = 2;

    logic [CW_T-1:0]     enc_row;
    logic [CW_T-1:0]     store_row;
    logic [NBANK-1:0]    bank_we;
    logic [NBANK-1:0]    bank_re;
    logic [ROW_AW-1:0]   bank_raddr [NBANK];
    logic [CW_T-1:0]     bank_q     [NBANK];
    logic [NBANK-1:0]    bank_vld;
    logic [ROW_BITS-1:0] dec_data   [NBANK];
    logic [WORDS-1:0]    dec_cerr   [NBANK];
    logic [WORDS-1:0]    dec_uerr   [NBANK];

    slice_row_encode #(.WORDS(WORDS)) u_enc (
        .row_data (wr_data),
        .row_cw   (enc_row)
    );

    assign store_row = enc_row ^ wr_flip;

    assign bank_re[BANK_OPERAND]    = od_rd_en;
    assign bank_re[BANK_WEIGHT]     = wt_rd_en;
    assign bank_raddr[BANK_OPERAND] = od_rd_row;
    assign bank_raddr[BANK_WEIGHT]  = wt_rd_row;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_we[b] = wr_en && (wr_bank == b[0]);

        slice_mem_bank #(.ROWS(ROWS), .CW_T(CW_T)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .we       (bank_we[b]),
            .waddr    (wr_row),
            .wdata    (store_row),
            .re       (bank_re[b]),
            .raddr    (bank_raddr[b]),
            .rdata_q  (bank_q[b]),
            .rvalid_q (bank_vld[b])
        );

        slice_row_decode #(.WORDS(WORDS)) u_dec (
            .row_cw    (bank_q[b]),
            .row_data  (dec_data[b]),
            .word_cerr (dec_cerr[b]),
            .word_uerr (dec_uerr[b])
        );
    end

    assign od_rd_valid = bank_vld[BANK_OPERAND];
    assign od_rd_data  = dec_data[BANK_OPERAND];
    assign od_rd_cerr  = bank_vld[BANK_OPERAND] ? dec_cerr[BANK_OPERAND] : '0;
    assign od_rd_uerr  = bank_vld[BANK_OPERAND] ? dec_uerr[BANK_OPERAND] : '0;

    assign wt_rd_valid = bank_vld[BANK_WEIGHT];
    assign wt_rd_data  = dec_data[BANK_WEIGHT];
    assign wt_rd_cerr  = bank_vld[BANK_WEIGHT] ? dec_cerr[BANK_WEIGHT] : '0;
    assign wt_rd_uerr  = bank_vld[BANK_WEIGHT] ? dec_uerr[BANK_WEIGHT] : '0;
endmodule

// File: rtl/dual_bank_ecc_mem_chk.sv
module dual_bank_ecc_mem_chk #(
    parameter int ROW_BITS = 2048,
    parameter int WORDS    = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                od_rd_en,
    input logic                od_rd_valid,
    input logic [ROW_BITS-1:0] od_rd_data,
    input logic [WORDS-1:0]    od_rd_cerr,
    input logic [WORDS-1:0]    od_rd_uerr,
    input logic                wt_rd_en,
    input logic                wt_rd_valid,
    input logic [ROW_BITS-1:0] wt_rd_data,
    input logic [WORDS-1:0]    wt_rd_cerr,
    input logic [WORDS-1:0]    wt_rd_uerr
);
    AST_OD_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        od_rd_en |=> od_rd_valid);                                      // R4
    AST_WT_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        wt_rd_en |=> wt_rd_valid);                                      // R4
    AST_OD_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !od_rd_en |=> !od_rd_valid);                                    // R4
    AST_WT_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !wt_rd_en |=> !wt_rd_valid);                                    // R4
    AST_OD_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !od_rd_valid |-> (od_rd_cerr == '0 && od_rd_uerr == '0));       // R9
    AST_WT_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wt_rd_valid |-> (wt_rd_cerr == '0 && wt_rd_uerr == '0));       // R9
    AST_OD_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !od_rd_en |=> $stable(od_rd_data));                             // R9
    AST_WT_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !wt_rd_en |=> $stable(wt_rd_data));                             // R9
    AST_OD_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        (od_rd_cerr & od_rd_uerr) == '0);                               // R10
    AST_WT_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        (wt_rd_cerr & wt_rd_uerr) == '0);                               // R10
endmodule

bind dual_bank_ecc_mem dual_bank_ecc_mem_chk #(
    .ROW_BITS (ROW_BITS),
    .WORDS    (WORDS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .od_rd_en    (od_rd_en),
    .od_rd_valid (od_rd_valid),
    .od_rd_data  (od_rd_data),
    .od_rd_cerr  (od_rd_cerr),
    .od_rd_uerr  (od_rd_uerr),
    .wt_rd_en    (wt_rd_en),
    .wt_rd_valid (wt_rd_valid),
    .wt_rd_data  (wt_rd_data),
    .wt_rd_cerr  (wt_rd_cerr),
    .wt_rd_uerr  (wt_rd_uerr)
);

// File: tb/dual_bank_ecc_mem_tb.sv
module dual_bank_ecc_mem_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS       = 2048;
    localparam int DW         = 2048;
    localparam int WORDS      = 32;
    localparam int CWT        = WORDS * 72;
    localparam int AW         = 11;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic            wr_bank = 1'b0;
    logic [AW-1:0]   wr_row = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [CWT-1:0]  wr_flip = '0;
    logic            od_rd_en = 1'b0;
    logic [AW-1:0]   od_rd_row = '0;
    logic            od_rd_valid;
    logic [DW-1:0]   od_rd_data;
    logic [WORDS-1:0] od_rd_cerr, od_rd_uerr;
    logic            wt_rd_en = 1'b0;
    logic [AW-1:0]   wt_rd_row = '0;
    logic            wt_rd_valid;
    logic [DW-1:0]   wt_rd_data;
    logic [WORDS-1:0] wt_rd_cerr, wt_rd_uerr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bank_ecc_mem dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row),
        .wr_data(wr_data), .wr_flip(wr_flip),
        .od_rd_en(od_rd_en), .od_rd_row(od_rd_row), .od_rd_valid(od_rd_valid),
        .od_rd_data(od_rd_data), .od_rd_cerr(od_rd_cerr), .od_rd_uerr(od_rd_uerr),
        .wt_rd_en(wt_rd_en), .wt_rd_row(wt_rd_row), .wt_rd_valid(wt_rd_valid),
        .wt_rd_data(wt_rd_data), .wt_rd_cerr(wt_rd_cerr), .wt_rd_uerr(wt_rd_uerr)
    );

    function automatic logic [DW-1:0] mk_row(input logic [31:0] seed);
        logic [DW-1:0] r;
        for (int w = 0; w < WORDS; w++)
            r[w*64 +: 64] = {seed, 32'(w)} ^ 64'h5A3C_96E1_0F87_D24B;
        return r;
    endfunction

    task automatic chk_row(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s row data act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_vec(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge, one rising edge captures it.
    task automatic wr_row_t(input logic bank, input logic [AW-1:0] row,
                            input logic [DW-1:0] d, input logic [CWT-1:0] flip);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = bank; wr_row = row; wr_data = d; wr_flip = flip;
        @(negedge clk);
        wr_en = 1'b0; wr_flip = '0;
    endtask

    task automatic rd_both(input logic [AW-1:0] orow, input logic [AW-1:0] wrow);
        @(negedge clk);
        od_rd_en = 1'b1; od_rd_row = orow;
        wt_rd_en = 1'b1; wt_rd_row = wrow;
        @(negedge clk);
        od_rd_en = 1'b0; wt_rd_en = 1'b0;
    endtask

    task automatic t_reset;
        chk_vec("R1", "od valid", 64'(od_rd_valid), 64'd0);
        chk_vec("R1", "wt valid", 64'(wt_rd_valid), 64'd0);
        chk_row("R1", od_rd_data, '0);
        chk_row("R1", wt_rd_data, '0);
        chk_vec("R1", "od flags", 64'({od_rd_cerr, od_rd_uerr}), 64'd0);
        chk_vec("R1", "wt flags", 64'({wt_rd_cerr, wt_rd_uerr}), 64'd0);
    endtask

    task automatic t_bank_select;
        wr_row_t(1'b0, 11'd5, mk_row(32'h1111), '0);
        wr_row_t(1'b1, 11'd5, mk_row(32'h2222), '0);
        rd_both(11'd5, 11'd5);
        chk_vec("R4", "od valid", 64'(od_rd_valid), 64'd1);
        chk_row("R2", od_rd_data, mk_row(32'h1111));
        chk_row("R2", wt_rd_data, mk_row(32'h2222));
        chk_vec("R8", "clean flags", 64'({od_rd_cerr, wt_rd_uerr}), 64'd0);
    endtask

    task automatic t_same_cycle;
        wr_row_t(1'b0, 11'd7, mk_row(32'h3300), '0);
        // write new row 7 in operand bank while reading it and weight row 5
        @(negedge clk);
        wr_en = 1'b1; wr_bank = 1'b0; wr_row = 11'd7; wr_data = mk_row(32'h3301);
        od_rd_en = 1'b1; od_rd_row = 11'd7;
        wt_rd_en = 1'b1; wt_rd_row = 11'd5;
        @(negedge clk);
        wr_en = 1'b0; od_rd_en = 1'b0; wt_rd_en = 1'b0;
        chk_row("R5", od_rd_data, mk_row(32'h3300));
        chk_row("R3", wt_rd_data, mk_row(32'h2222));
        @(negedge clk);
        chk_vec("R4", "od valid idle", 64'(od_rd_valid), 64'd0);
        chk_vec("R9", "od flags idle", 64'({od_rd_cerr, od_rd_uerr}), 64'd0);
        chk_row("R9", od_rd_data, mk_row(32'h3300));
        rd_both(11'd7, 11'd5);
        chk_row("R5", od_rd_data, mk_row(32'h3301));
    endtask

    task automatic t_single_flip;
        logic [CWT-1:0] f;
        f = '0;
        f[3*72 + 10] = 1'b1;
        f[17*72 + 0] = 1'b1;
        wr_row_t(1'b1, 11'd9, mk_row(32'h4444), f);
        rd_both(11'd5, 11'd9);
        chk_row("R6", wt_rd_data, mk_row(32'h4444));
        chk_vec("R6", "cerr", 64'(wt_rd_cerr), 64'((32'd1 << 3) | (32'd1 << 17)));
        chk_vec("R6", "uerr", 64'(wt_rd_uerr), 64'd0);
        chk_vec("R8", "od untouched cerr", 64'(od_rd_cerr), 64'd0);
    endtask

    task automatic t_double_flip;
        logic [CWT-1:0] f;
        logic [DW-1:0]  exp;
        f = '0;
        f[5*72 + 2]   = 1'b1;
        f[5*72 + 40]  = 1'b1;
        f[20*72 + 71] = 1'b1;
        exp = mk_row(32'h5555);
        wr_row_t(1'b0, 11'd12, exp, f);
        rd_both(11'd12, 11'd5);
        chk_vec("R7", "uerr", 64'(od_rd_uerr), 64'(32'd1 << 5));
        chk_vec("R8", "cerr", 64'(od_rd_cerr), 64'(32'd1 << 20));
        chk_vec("R8", "word20", od_rd_data[20*64 +: 64], exp[20*64 +: 64]);
        chk_vec("R8", "word0", od_rd_data[63:0], exp[63:0]);
    endtask

    task automatic t_last_row;
        wr_row_t(1'b0, AW'(ROWS-1), mk_row(32'h6600), '0);
        wr_row_t(1'b1, AW'(ROWS-1), mk_row(32'h6601), '0);
        rd_both(AW'(ROWS-1), AW'(ROWS-1));
        chk_row("R11", od_rd_data, mk_row(32'h6600));
        chk_row("R11", wt_rd_data, mk_row(32'h6601));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bank_select();
        t_same_cycle();
        t_single_flip();
        t_double_flip();
        t_last_row();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog act=timeout exp=completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule